// File: doc/BRIEF.md
# Memory-Stage Address Translation Controller

This block steers one load or store at a time through the memory stage of a pipeline that uses virtual addresses. A non-memory instruction goes straight to the downstream stage. A memory instruction first sits out an access-latency window. The window is longer when an early look into the translation buffer misses. After the window the block does the real translation lookup. On a miss it probes the data cache for the page-table entry. If that probe also misses, it sends a page-table load into the shared miss queue and holds the upstream stage until the translation is available.

Once a physical address exists, the block probes the data cache for the data. A hit or a forwarded result sends the instruction downstream. A merged or accepted miss frees the upstream latch without a downstream send. A full queue makes the block retry the request every cycle. The translation buffer, the cache tags, the miss queue and the page-table walker that computes entry addresses and frame numbers all sit outside the block and answer its probes in the same cycle. Four saturating counters record translation-buffer and cache hits and misses.

FSM states: IDLE (accept an instruction), WAIT (latency window), TLOOK (translation lookup), PRETRY (page-table request retry), PTW (waiting for a returned translation), DACC (data access), DRETRY (data request retry). Transitions:
- IDLE→WAIT on a memory instruction.
- WAIT→TLOOK when the window ends.
- TLOOK/PRETRY→DACC on a buffer hit, an entry-probe hit or a forward hit.
- TLOOK/PRETRY→PTW on a merge or an accept.
- TLOOK/PRETRY→PRETRY on a full queue.
- PTW→DACC on `xlate_done`.
- DACC→IDLE on a hit, forward, merge or accept.
- DACC→DRETRY on a full queue.
- DRETRY→IDLE on a hit or an accept.

Top module: `mem_xlate_ctrl`

## Requirements
- R1: With `in_valid` high and `in_is_mem` low in IDLE, `out_valid` and `in_consume` are high in that same cycle, and `out_addr` equals `in_vaddr`.
- R2: A memory instruction spends DC_LAT-1 cycles in WAIT when the early buffer lookup (done in IDLE on the VPN `in_vaddr[VA_W-1:PB]`) hits, and 2*(DC_LAT-1) cycles when it misses. The early lookup changes no counter.
- R3: The physical address is the frame number shifted left by PB = log2(PAGE_SIZE), OR'd with the low PB bits of the virtual address. This address is driven on `dc_addr` and `mq_addr` for the data access and on `out_addr` with `out_valid`.
- R4: On a buffer miss, `pt_entry_addr` is probed on `dc_addr`. On a hit, the block asserts `tlb_wr_en` with the current VPN and `pt_pfn`, counts one cache hit and one buffer miss, and moves to the data access.
- R5: On an entry-probe miss, the block raises `mq_req` with `mq_is_pte`=1 and `mq_addr`=`pt_entry_addr`. The responses rank forward > merge > accept. A forward installs the translation and continues with no stall. A merge or an accept waits in PTW with `up_stall` high.
- R6: When a page-table request gets no response (queue full), the block stalls upstream and retries the whole lookup every cycle. That attempt adds no buffer miss; each entry probe still counts a cache miss.
- R7: Data access: a cache hit or a forward gives `out_valid` and `in_consume`. A merge or an accept gives `in_consume` alone. No response moves to DRETRY. A data request carries `mq_is_pte`=0.
- R8: In PTW, `xlate_done` forms the physical address from `pt_pfn`, drops `up_stall` and starts the data access on the next cycle, with no buffer install.
- R9: In DRETRY the cache is probed again each cycle, and only hits are counted. A hit sends downstream. Otherwise only `mq_accept` frees the upstream latch.
- R10: The counters `cnt_tlb_hit`, `cnt_tlb_miss`, `cnt_dc_hit` and `cnt_dc_miss` are CNT_W bits wide, count up by one per event and stop at all ones.
- R11: After reset the block is in IDLE with all counters at zero and `out_valid`, `in_consume` and `up_stall` low.
- R12: `up_stall` is high exactly in PRETRY and PTW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream latch holds an instruction |
| in_is_mem | input | 1 | Instruction is a load or store |
| in_vaddr | input | VA_W | Virtual address of the access |
| in_consume | output | 1 | Upstream latch is freed this cycle |
| up_stall | output | 1 | Hold the upstream stage |
| out_valid | output | 1 | Instruction sent downstream this cycle |
| out_addr | output | VA_W | Address sent with the instruction |
| lk_vpn | output | VPN_W | VPN for buffer lookup and page-table walk |
| tlb_hit | input | 1 | Buffer holds a translation for lk_vpn |
| tlb_pfn | input | VPN_W | Frame number from the buffer |
| tlb_wr_en | output | 1 | Install a translation |
| tlb_wr_vpn | output | VPN_W | VPN to install |
| tlb_wr_pfn | output | VPN_W | Frame number to install |
| pt_entry_addr | input | VA_W | Page-table entry address for lk_vpn |
| pt_pfn | input | VPN_W | Frame number from the page table for lk_vpn |
| dc_probe | output | 1 | Data cache probe valid |
| dc_addr | output | VA_W | Data cache probe address |
| dc_hit | input | 1 | Probe hit |
| mq_req | output | 1 | Miss-queue request |
| mq_addr | output | VA_W | Miss-queue request address |
| mq_is_pte | output | 1 | Request is a page-table load |
| mq_fwd_hit | input | 1 | Request satisfied by forwarding |
| mq_merge_hit | input | 1 | Request merged with a pending miss |
| mq_accept | input | 1 | Request took a new queue entry |
| xlate_done | input | 1 | Requested translation has returned |
| cnt_tlb_hit | output | CNT_W | Buffer hit count |
| cnt_tlb_miss | output | CNT_W | Buffer miss count |
| cnt_dc_hit | output | CNT_W | Cache hit count |
| cnt_dc_miss | output | CNT_W | Cache miss count |

## Verification
The assertions check on every cycle the properties that tie one cycle to the next:
- a downstream send always frees the upstream latch;
- a page-table request with no response raises the stall on the next cycle;
- a returned translation releases the stall and starts a data probe;
- a buffer install is followed by a data probe with the right page offset;
- no counter ever moves down.

Only the bench sweep shows the cycle counts of the wait window and of each retry path, the exact physical address, which response ends in a downstream send, and the counter totals, including the point where they saturate. The sweep covers all combinations of early hit, entry-probe hit, page-table response, data hit and data response.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_WAIT,
        XS_TLOOK,
        XS_PRETRY,
        XS_PTW,
        XS_DACC,
        XS_DRETRY
    } xstate_t;

    localparam int NUM_STATS   = 4;
    localparam int ST_TLB_HIT  = 0;
    localparam int ST_TLB_MISS = 1;
    localparam int ST_DC_HIT   = 2;
    localparam int ST_DC_MISS  = 3;

endpackage

// File: rtl/xlate_wait_timer.sv
module xlate_wait_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign last = (cnt_q == TW'(1));

    // R2: a window that reaches its final cycle is empty afterwards
    a_r2_window_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/xlate_addr_form.sv
module xlate_addr_form #(
    parameter int VA_W = 16,
    parameter int PB   = 8
) (
    input  logic [VA_W-PB-1:0] frame,
    input  logic [VA_W-1:0]    vaddr,
    output logic [VA_W-1:0]    paddr
);

    localparam logic [VA_W-1:0] OFF_MASK = (VA_W'(1) << PB) - VA_W'(1);

    always_comb begin
        paddr = (VA_W'(frame) << PB) | (vaddr & OFF_MASK);
    end

endmodule

// File: rtl/xlate_stat_bank.sv
module xlate_stat_bank #(
    parameter int N     = 4,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              inc,
    output logic [N-1:0][CNT_W-1:0]   cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    for (genvar g = 0; g < N; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[g] <= '0;
            end else if (inc[g] && cnt[g] != TOP) begin
                cnt[g] <= cnt[g] + CNT_W'(1);
            end
        end

        // R10: a counter never moves down
        a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt[g] >= $past(cnt[g])));
    end

endmodule

// File: rtl/mem_xlate_ctrl.sv
module mem_xlate_ctrl
    import xlate_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PAGE_SIZE = 256,
    parameter int DC_LAT    = 3,
    parameter int CNT_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic                           in_is_mem,
    input  logic [VA_W-1:0]                in_vaddr,
    output logic                           in_consume,
    output logic                           up_stall,
    output logic                           out_valid,
    output logic [VA_W-1:0]                out_addr,
    output logic [VA_W-$clog2(PAGE_SIZE)-1:0] lk_vpn,
    input  logic                           tlb_hit,
    input  logic [VA_W-$clog2(PAGE_SIZE)-1:0] tlb_pfn,
    output logic                           tlb_wr_en,
    output logic [VA_W-$clog2(PAGE_SIZE)-1:0] tlb_wr_vpn,
    output logic [VA_W-$clog2(PAGE_SIZE)-1:0] tlb_wr_pfn,
    input  logic [VA_W-1:0]                pt_entry_addr,
    input  logic [VA_W-$clog2(PAGE_SIZE)-1:0] pt_pfn,
    output logic                           dc_probe,
    output logic [VA_W-1:0]                dc_addr,
    input  logic                           dc_hit,
    output logic                           mq_req,
    output logic [VA_W-1:0]                mq_addr,
    output logic                           mq_is_pte,
    input  logic                           mq_fwd_hit,
    input  logic                           mq_merge_hit,
    input  logic                           mq_accept,
    input  logic                           xlate_done,
    output logic [CNT_W-1:0]               cnt_tlb_hit,
    output logic [CNT_W-1:0]               cnt_tlb_miss,
    output logic [CNT_W-1:0]               cnt_dc_hit,
    output logic [CNT_W-1:0]               cnt_dc_miss
);

    localparam int PB        = $clog2(PAGE_SIZE);
    localparam int VPN_W     = VA_W - PB;
    localparam int WAIT_BASE = DC_LAT - 1;
    localparam int WAIT_MAX  = 2 * WAIT_BASE;
    localparam int TW        = $clog2(WAIT_MAX + 1);

    xstate_t state_q, state_d;

    logic [VA_W-1:0]      vaddr_q;
    logic [VA_W-1:0]      paddr_q;
    logic [VA_W-1:0]      paddr_new;
    logic [VPN_W-1:0]     frame_sel;
    logic                 ld_paddr;
    logic                 tmr_load;
    logic [TW-1:0]        tmr_val;
    logic                 tmr_last;
    logic [NUM_STATS-1:0] stat_inc;
    logic [NUM_STATS-1:0][CNT_W-1:0] stat_cnt;

    // ---------------- sub-blocks ----------------
    xlate_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    xlate_addr_form #(.VA_W(VA_W), .PB(PB)) u_form (
        .frame (frame_sel),
        .vaddr (vaddr_q),
        .paddr (paddr_new)
    );

    xlate_stat_bank #(.N(NUM_STATS), .CNT_W(CNT_W)) u_stats (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stat_inc),
        .cnt   (stat_cnt)
    );

    assign cnt_tlb_hit  = stat_cnt[ST_TLB_HIT];
    assign cnt_tlb_miss = stat_cnt[ST_TLB_MISS];
    assign cnt_dc_hit   = stat_cnt[ST_DC_HIT];
    assign cnt_dc_miss  = stat_cnt[ST_DC_MISS];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- address registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            paddr_q <= '0;
        end else begin
            if (state_q == XS_IDLE && in_valid && in_is_mem) begin
                vaddr_q <= in_vaddr;
            end
            if (ld_paddr) begin
                paddr_q <= paddr_new;
            end
        end
    end

    // ---------------- next state and outputs ----------------
    always_comb begin
        state_d    = state_q;
        in_consume = 1'b0;
        up_stall   = 1'b0;
        out_valid  = 1'b0;
        out_addr   = paddr_q;
        lk_vpn     = vaddr_q[VA_W-1:PB];
        tlb_wr_en  = 1'b0;
        tlb_wr_vpn = vaddr_q[VA_W-1:PB];
        tlb_wr_pfn = pt_pfn;
        dc_probe   = 1'b0;
        dc_addr    = paddr_q;
        mq_req     = 1'b0;
        mq_addr    = paddr_q;
        mq_is_pte  = 1'b0;
        frame_sel  = pt_pfn;
        ld_paddr   = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = TW'(WAIT_MAX);
        stat_inc   = '0;

        unique case (state_q)
            XS_IDLE: begin
                lk_vpn = in_vaddr[VA_W-1:PB];
                if (in_valid) begin
                    if (!in_is_mem) begin
                        out_valid  = 1'b1;
                        in_consume = 1'b1;
                        out_addr   = in_vaddr;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = tlb_hit ? TW'(WAIT_BASE) : TW'(WAIT_MAX);
                        state_d  = XS_WAIT;
                    end
                end
            end

            XS_WAIT: begin
                if (tmr_last) begin
                    state_d = XS_TLOOK;
                end
            end

            XS_TLOOK, XS_PRETRY: begin
                up_stall = (state_q == XS_PRETRY);
                if (tlb_hit) begin
                    stat_inc[ST_TLB_HIT] = 1'b1;
                    frame_sel = tlb_pfn;
                    ld_paddr  = 1'b1;
                    state_d   = XS_DACC;
                end else begin
                    dc_probe = 1'b1;
                    dc_addr  = pt_entry_addr;
                    if (dc_hit) begin
                        stat_inc[ST_DC_HIT]   = 1'b1;
                        stat_inc[ST_TLB_MISS] = 1'b1;
                        tlb_wr_en = 1'b1;
                        ld_paddr  = 1'b1;
                        state_d   = XS_DACC;
                    end else begin
                        stat_inc[ST_DC_MISS] = 1'b1;
                        mq_req    = 1'b1;
                        mq_addr   = pt_entry_addr;
                        mq_is_pte = 1'b1;
                        if (mq_fwd_hit) begin
                            stat_inc[ST_TLB_MISS] = 1'b1;
                            tlb_wr_en = 1'b1;
                            ld_paddr  = 1'b1;
                            state_d   = XS_DACC;
                        end else if (mq_merge_hit || mq_accept) begin
                            stat_inc[ST_TLB_MISS] = 1'b1;
                            state_d = XS_PTW;
                        end else begin
                            state_d = XS_PRETRY;
                        end
                    end
                end
            end

            XS_PTW: begin
                up_stall = 1'b1;
                if (xlate_done) begin
                    ld_paddr = 1'b1;
                    state_d  = XS_DACC;
                end
            end

            XS_DACC: begin
                dc_probe = 1'b1;
                if (dc_hit) begin
                    stat_inc[ST_DC_HIT] = 1'b1;
                    out_valid  = 1'b1;
                    in_consume = 1'b1;
                    state_d    = XS_IDLE;
                end else begin
                    stat_inc[ST_DC_MISS] = 1'b1;
                    mq_req = 1'b1;
                    if (mq_fwd_hit) begin
                        out_valid  = 1'b1;
                        in_consume = 1'b1;
                        state_d    = XS_IDLE;
                    end else if (mq_merge_hit || mq_accept) begin
                        in_consume = 1'b1;
                        state_d    = XS_IDLE;
                    end else begin
                        state_d = XS_DRETRY;
                    end
                end
            end

            XS_DRETRY: begin
                dc_probe = 1'b1;
                if (dc_hit) begin
                    stat_inc[ST_DC_HIT] = 1'b1;
                    out_valid  = 1'b1;
                    in_consume = 1'b1;
                    state_d    = XS_IDLE;
                end else begin
                    mq_req = 1'b1;
                    if (mq_accept) begin
                        in_consume = 1'b1;
                        state_d    = XS_IDLE;
                    end
                end
            end

            default: state_d = XS_IDLE;
        endcase
    end

    // ---------------- assertions ----------------
    // R7: every downstream send frees the upstream latch
    a_r7_send_frees: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_consume);

    // R6: an unanswered page-table request stalls upstream next cycle
    a_r6_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (mq_req && mq_is_pte && !mq_fwd_hit && !mq_merge_hit && !mq_accept)
        |=> up_stall);

    // R8: a returned translation releases the stall and starts the data probe
    a_r8_done_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_PTW && xlate_done) |=> (!up_stall && dc_probe && !mq_is_pte));

    // R4: an install is followed by a data probe carrying the page offset
    a_r4_install_then_probe: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |=> (dc_probe && dc_addr[PB-1:0] == vaddr_q[PB-1:0]));

    // R3: a translated send keeps the page offset of the virtual address
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && state_q != XS_IDLE) |-> (out_addr[PB-1:0] == vaddr_q[PB-1:0]));

endmodule

// File: tb/sim_mem_xlate_ctrl.sv
module sim_mem_xlate_ctrl;

    localparam int VA_W = 16;
    localparam int PSZ  = 256;
    localparam int LAT  = 3;
    localparam int CW   = 4;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_is_mem = 1'b0;
    logic [15:0] in_vaddr = '0;
    logic        in_consume, up_stall, out_valid;
    logic [15:0] out_addr;
    logic [7:0]  lk_vpn, tlb_pfn, tlb_wr_vpn, tlb_wr_pfn, pt_pfn;
    logic        tlb_hit, tlb_wr_en;
    logic [15:0] pt_entry_addr, dc_addr, mq_addr;
    logic        dc_probe, dc_hit, mq_req, mq_is_pte;
    logic        mq_fwd_hit, mq_merge_hit, mq_accept;
    logic        xlate_done = 1'b0;
    logic [CW-1:0] c_th, c_tm, c_dh, c_dm;

    int checks = 0, errors = 0;
    logic tlb_v [256];
    bit   pte_hit_cfg = 0, data_hit_cfg = 0;
    int   pte_mode = 0, data_mode = 0;
    int   pte_full_left = 0, data_full_left = 0;
    int   e_th = 0, e_tm = 0, e_dh = 0, e_dm = 0;
    int   wr_seen = 0;

    always #2.5 clk = ~clk;

    mem_xlate_ctrl #(.VA_W(VA_W), .PAGE_SIZE(PSZ), .DC_LAT(LAT), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_mem(in_is_mem),
        .in_vaddr(in_vaddr), .in_consume(in_consume), .up_stall(up_stall),
        .out_valid(out_valid), .out_addr(out_addr), .lk_vpn(lk_vpn),
        .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_wr_en(tlb_wr_en),
        .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_pfn(tlb_wr_pfn),
        .pt_entry_addr(pt_entry_addr), .pt_pfn(pt_pfn), .dc_probe(dc_probe),
        .dc_addr(dc_addr), .dc_hit(dc_hit), .mq_req(mq_req), .mq_addr(mq_addr),
        .mq_is_pte(mq_is_pte), .mq_fwd_hit(mq_fwd_hit), .mq_merge_hit(mq_merge_hit),
        .mq_accept(mq_accept), .xlate_done(xlate_done), .cnt_tlb_hit(c_th),
        .cnt_tlb_miss(c_tm), .cnt_dc_hit(c_dh), .cnt_dc_miss(c_dm)
    );

    // external models: translation = vpn ^ 8'h5A, entry address = {8'hF0, vpn}
    always_comb begin
        tlb_hit       = tlb_v[lk_vpn];
        tlb_pfn       = lk_vpn ^ 8'h5A;
        pt_pfn        = lk_vpn ^ 8'h5A;
        pt_entry_addr = {8'hF0, lk_vpn};
        dc_hit        = dc_probe && ((dc_addr[15:8] == 8'hF0) ? pte_hit_cfg : data_hit_cfg);
    end

    // mode: 0 forward, 1 merge, 2 accept, 3 two full cycles then accept
    always_comb begin
        mq_fwd_hit = 1'b0; mq_merge_hit = 1'b0; mq_accept = 1'b0;
        if (mq_req) begin
            if (mq_is_pte ? (pte_full_left == 0) : (data_full_left == 0)) begin
                case (mq_is_pte ? pte_mode : data_mode)
                    0:       mq_fwd_hit   = 1'b1;
                    1:       mq_merge_hit = 1'b1;
                    default: mq_accept    = 1'b1;
                endcase
            end
        end
    end

    always @(posedge clk) begin
        if (mq_req && mq_is_pte && pte_full_left > 0) pte_full_left <= pte_full_left - 1;
        if (mq_req && !mq_is_pte && data_full_left > 0) data_full_left <= data_full_left - 1;
        if (tlb_wr_en) tlb_v[tlb_wr_vpn] <= 1'b1;
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic check_counters(input string tag);
        check({tag, " R10 tlb hit count"},  int'(c_th), sat(e_th));
        check({tag, " R10 R6 tlb miss count"}, int'(c_tm), sat(e_tm));
        check({tag, " R10 R9 cache hit count"}, int'(c_dh), sat(e_dh));
        check({tag, " R10 cache miss count"}, int'(c_dm), sat(e_dm));
    endtask

    task automatic run_nonmem(input logic [15:0] va);
        in_valid = 1'b1; in_is_mem = 1'b0; in_vaddr = va;
        #1;
        check("R1 pass-through send", int'(out_valid && in_consume), 1);
        check("R1 pass-through address", int'(out_addr), int'(va));
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        check_counters("R1");
    endtask

    task automatic run_case(input bit pre, input bit pte_hit, input int pm,
                            input bit d_hit, input int dm, input logic [7:0] vpn,
                            input logic [7:0] off);
        int w, fp, p, fd, exp_lat, exp_stall, exp_wr, lat, stalls, pend;
        bit exp_out, out_seen;
        logic [15:0] exp_pa;
        tlb_v[vpn] = pre;
        pte_hit_cfg = pte_hit; data_hit_cfg = d_hit;
        pte_mode = pm; data_mode = dm;
        pte_full_left  = (pm == 3) ? 2 : 0;
        data_full_left = (dm == 3) ? 2 : 0;
        exp_pa = {vpn ^ 8'h5A, off};
        w = pre ? (LAT - 1) : 2 * (LAT - 1);
        fp = 0; p = 0; exp_wr = 0;
        if (pre) e_th++;
        else begin
            e_tm++;
            if (pte_hit) begin e_dh++; exp_wr = 1; end
            else begin
                fp = (pm == 3) ? 2 : 0;
                e_dm += 1 + fp;
                if (pm == 0) exp_wr = 1; else p = 2;
            end
        end
        if (d_hit) begin e_dh++; fd = 0; exp_out = 1; end
        else begin
            e_dm++;
            fd = (dm == 3) ? 2 : 0;
            exp_out = (dm == 0);
        end
        exp_lat = w + 1 + fp + p + 1 + fd;
        exp_stall = fp + p;

        wr_seen = 0; stalls = 0; pend = 0; lat = -1; out_seen = 0;
        in_valid = 1'b1; in_is_mem = 1'b1; in_vaddr = {vpn, off};
        #1;
        check("R2 no consume while accepting a memory op", int'(in_consume), 0);
        for (int c = 1; c <= 80; c++) begin
            @(posedge clk); #1;
            xlate_done = 1'b0;
            if (up_stall) stalls++;
            if (tlb_wr_en) begin
                wr_seen++;
                check("R4 installed frame", int'(tlb_wr_pfn), int'(vpn ^ 8'h5A));
            end
            if (mq_req && mq_is_pte)
                check("R5 page-table request address", int'(mq_addr), int'({8'hF0, vpn}));
            if (mq_req && !mq_is_pte)
                check("R3 data request address", int'(mq_addr), int'(exp_pa));
            if (out_valid) begin
                out_seen = 1;
                check("R3 physical address", int'(out_addr), int'(exp_pa));
            end
            if (in_consume) begin lat = c; break; end
            if (pend > 0) begin
                pend--;
                if (pend == 0) xlate_done = 1'b1;
            end
            if (mq_req && mq_is_pte && (mq_merge_hit || mq_accept)) pend = 2;
        end
        in_valid = 1'b0;
        check("R2 R8 R9 cycles to consume", lat, exp_lat);
        check("R7 downstream send", int'(out_seen), int'(exp_out));
        check("R12 stall cycles", stalls, exp_stall);
        check("R4 R5 R8 install count", wr_seen, exp_wr);
        @(posedge clk); #1;
        check_counters("case");
        check("R12 stall low after consume", int'(up_stall), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        logic [7:0] vpn;
        for (int i = 0; i < 256; i++) tlb_v[i] = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R11 out_valid after reset", int'(out_valid), 0);
        check("R11 consume after reset", int'(in_consume), 0);
        check("R11 stall after reset", int'(up_stall), 0);
        check_counters("R11");

        run_nonmem(16'h1234);
        run_nonmem(16'hFFFF);
        run_nonmem(16'h0000);

        idx = 0;
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
                for (int pm = 0; pm < 4; pm++)
                    for (int d = 0; d < 2; d++)
                        for (int dm = 0; dm < 4; dm++) begin
                            vpn = 8'(idx * 7 + 3);
                            if (vpn == 8'hAA) vpn = 8'h11;
                            run_case(a[0], b[0], pm, d[0], dm, vpn, 8'(idx * 13 + 5));
                            idx++;
                        end

        run_nonmem(16'hA5C3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule